// File: doc/BRIEF.md
# Mode-Tagged Decode Queue

This block sits between instruction fetch and the microcode sequencer. Each opcode handed over by fetch is turned into a microcode entry point straight away, then parked in a short in-order queue until the execute stage takes it. The lookup has one more input beside the opcode: the protection-enable bit (`pe`) as it stands in the decode cycle. Most opcodes ignore that bit. Three classes do not: a segment-register load from a general register, halt, and opcodes that are forbidden in real mode. Each queued entry stores the `pe` value it was decoded under, and it keeps that path however `pe` moves later.

The execute stage looks at the live `pe` on its own. A register-to-segment load that was decoded in real mode but reaches execute with `pe` set is marked so that only the visible selector gets written and the base is left alone.

A taken jump empties the queue, so every later opcode is decoded again under the current mode. If `pe` is written and no flush follows, the block counts how many real-decoded entries then execute under a set `pe`. The third such entry raises `shutdown`, which stays high until reset.

Both stream sides follow valid/ready rules:

- **Decode side:** a transfer happens when `dec_valid` and `dec_ready` are high at a clock edge. `dec_ready` is low only while the queue is full.
- **Execute side:** the head is held stable while `exe_valid` is high and `exe_ready` is low, except when a flush is taken.

Top module: `mode_decode_queue`

## Requirements
- R1: An opcode in 0x00–0x3F decodes to the entry point equal to its own value, whatever `pe` is at decode.
- R2: Opcode 0x40 (segment load from register) decodes to 64 in real mode and to 65 with `pe` set. Opcode 0x41 (halt) decodes to 66 in real mode and to 67 with `pe` set.
- R3: Opcodes 0x42 and 0x43 (protected-only) decode to 68 and 69 when `pe` is set. When decoded in real mode, both go to the trap entry point 70.
- R4: Every opcode from 0x44 to 0xFF decodes to the invalid-opcode entry point 71 in both modes.
- R5: `exe_dec_pe` and `exe_len` give the `pe` value and the length captured in the cycle the entry was accepted. A later change of `pe` alters neither them nor `exe_entry`.
- R6: Entries leave in the order they were accepted, and the queue holds up to 4 of them. `dec_ready` is low exactly when 4 entries are held, and `exe_valid` is low exactly when none are. A head that is not consumed stays unchanged.
- R7: When `jump_taken` is high at a clock edge, the queue is empty in the next cycle. A decode transfer in that same cycle is dropped. An execute transfer in that same cycle still completes.
- R8: `exe_sel_only` is high exactly when the head is valid, its entry point is 64 and the live `pe` is 1.
- R9: A stale execution is an execute transfer of an entry with `exe_dec_pe`=0 while `pe`=1. The stale count is cleared at any edge where `jump_taken` or `pe_wr` is high, and these take priority over a stale execution in the same cycle. The third stale execution counted since the last clear raises `shutdown` in the following cycle.
- R10: After reset the queue is empty, `dec_ready` is 1 and `shutdown` is 0. Once set, `shutdown` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dec_valid | input | 1 | Fetch offers an opcode |
| dec_ready | output | 1 | Queue can take an entry |
| dec_opcode | input | 8 | Opcode to decode |
| dec_len | input | LEN_W | Instruction length in bytes |
| pe | input | 1 | Live protection-enable bit |
| pe_wr | input | 1 | Pulse: `pe` is being written this cycle |
| jump_taken | input | 1 | Pulse: taken jump, flush the queue |
| exe_valid | output | 1 | Head entry is present |
| exe_ready | input | 1 | Execute consumes the head |
| exe_entry | output | 7 | Microcode entry point of the head |
| exe_dec_pe | output | 1 | `pe` captured when the head was decoded |
| exe_len | output | LEN_W | Length of the head instruction |
| exe_sel_only | output | 1 | Head updates the visible selector only |
| shutdown | output | 1 | Sticky triple-fault request |

## Verification
Two pairs of functions can land on the same clock edge.

- **Flush and decode:** a `jump_taken` pulse coincides with a decode transfer, and sometimes with an execute transfer as well. The model expects the queue to be empty in the next cycle, with the decoded opcode lost.
- **Stale execution and clearing:** a stale execution coincides with a `pe_wr` or `jump_taken` pulse. The model expects the count to restart, so `shutdown` must stay low unless three further stale executions follow.

Directed sequences set up both collisions deliberately, and a long random phase with frequent pulses of both kinds provokes them again. Every output is compared against the behavioural model each cycle.

// File: rtl/dq_pkg.sv
package dq_pkg;
  localparam int OP_W    = 8;
  localparam int ENTRY_W = 7;

  localparam logic [ENTRY_W-1:0] EP_SEGREG_REAL = 7'd64;
  localparam logic [ENTRY_W-1:0] EP_SEGREG_PROT = 7'd65;
  localparam logic [ENTRY_W-1:0] EP_HALT_REAL   = 7'd66;
  localparam logic [ENTRY_W-1:0] EP_HALT_PROT   = 7'd67;
  localparam logic [ENTRY_W-1:0] EP_PONLY_A     = 7'd68;
  localparam logic [ENTRY_W-1:0] EP_PONLY_B     = 7'd69;
  localparam logic [ENTRY_W-1:0] EP_TRAP        = 7'd70;
  localparam logic [ENTRY_W-1:0] EP_INVALID     = 7'd71;

  localparam logic [OP_W-1:0] OP_SEGREG = 8'h40;
  localparam logic [OP_W-1:0] OP_HALT   = 8'h41;
  localparam logic [OP_W-1:0] OP_PONLYA = 8'h42;
  localparam logic [OP_W-1:0] OP_PONLYB = 8'h43;
endpackage

// File: rtl/dq_entry_lut.sv
module dq_entry_lut
  import dq_pkg::*;
(
  input  logic [OP_W-1:0]    op,
  input  logic               dec_pe,
  output logic [ENTRY_W-1:0] entry
);
  always_comb begin
    if (op[7:6] == 2'b00) begin
      entry = {1'b0, op[5:0]};
    end else begin
      case (op)
        OP_SEGREG: entry = dec_pe ? EP_SEGREG_PROT : EP_SEGREG_REAL;
        OP_HALT:   entry = dec_pe ? EP_HALT_PROT : EP_HALT_REAL;
        OP_PONLYA,
        OP_PONLYB: entry = dec_pe ? (op[0] ? EP_PONLY_B : EP_PONLY_A) : EP_TRAP;
        default:   entry = EP_INVALID;
      endcase
    end
  end
endmodule

// File: rtl/dq_queue.sv
module dq_queue #(
  parameter int DEPTH = 4,
  parameter int W     = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         wr_valid,
  output logic         wr_ready,
  input  logic [W-1:0] wr_data,
  output logic         rd_valid,
  input  logic         rd_ready,
  output logic [W-1:0] rd_data
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [W-1:0]     slots [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] used;
  logic             do_wr, do_rd;

  assign wr_ready = (used != FULL);
  assign rd_valid = (used != '0);
  assign rd_data  = slots[rd_ptr];
  assign do_wr    = wr_valid && wr_ready && !flush;
  assign do_rd    = rd_valid && rd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      used   <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      used   <= '0;
    end else begin
      if (do_wr) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      if (do_wr && !do_rd)      used <= used + 1'b1;
      else if (do_rd && !do_wr) used <= used - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) slots[wr_ptr] <= wr_data;
  end
endmodule

// File: rtl/dq_mode_guard.sv
module dq_mode_guard #(
  parameter int LIMIT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_a,
  input  logic clear_b,
  input  logic stale_exec,
  output logic shutdown
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] TOP  = CNT_W'(LIMIT);
  localparam logic [CNT_W-1:0] NEAR = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] stale_cnt;
  logic             clr;

  assign clr = clear_a || clear_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stale_cnt <= '0;
      shutdown  <= 1'b0;
    end else begin
      if (clr)                             stale_cnt <= '0;
      else if (stale_exec && stale_cnt != TOP) stale_cnt <= stale_cnt + 1'b1;
      if (!clr && stale_exec && stale_cnt == NEAR) shutdown <= 1'b1;
    end
  end
endmodule

// File: rtl/mode_decode_queue.sv
module mode_decode_queue
  import dq_pkg::*;
#(
  parameter int DEPTH       = 4,
  parameter int LEN_W       = 4,
  parameter int STALE_LIMIT = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dec_valid,
  output logic               dec_ready,
  input  logic [OP_W-1:0]    dec_opcode,
  input  logic [LEN_W-1:0]   dec_len,
  input  logic               pe,
  input  logic               pe_wr,
  input  logic               jump_taken,
  output logic               exe_valid,
  input  logic               exe_ready,
  output logic [ENTRY_W-1:0] exe_entry,
  output logic               exe_dec_pe,
  output logic [LEN_W-1:0]   exe_len,
  output logic               exe_sel_only,
  output logic               shutdown
);
  localparam int SLOT_W = ENTRY_W + 1 + LEN_W;

  logic [ENTRY_W-1:0] lut_entry;
  logic [SLOT_W-1:0]  push_word, head_word;
  logic               stale_exec;

  dq_entry_lut u_lut (
    .op     (dec_opcode),
    .dec_pe (pe),
    .entry  (lut_entry)
  );

  assign push_word = {lut_entry, pe, dec_len};

  dq_queue #(.DEPTH(DEPTH), .W(SLOT_W)) u_queue (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (jump_taken),
    .wr_valid (dec_valid),
    .wr_ready (dec_ready),
    .wr_data  (push_word),
    .rd_valid (exe_valid),
    .rd_ready (exe_ready),
    .rd_data  (head_word)
  );

  assign exe_entry    = head_word[SLOT_W-1 -: ENTRY_W];
  assign exe_dec_pe   = head_word[LEN_W];
  assign exe_len      = head_word[LEN_W-1:0];
  assign exe_sel_only = exe_valid && (exe_entry == EP_SEGREG_REAL) && pe;
  assign stale_exec   = exe_valid && exe_ready && !exe_dec_pe && pe;

  dq_mode_guard #(.LIMIT(STALE_LIMIT)) u_guard (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_a    (jump_taken),
    .clear_b    (pe_wr),
    .stale_exec (stale_exec),
    .shutdown   (shutdown)
  );
endmodule

// File: rtl/mode_decode_queue_chk.sv
module mode_decode_queue_chk
  import dq_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               dec_ready,
  input logic               pe,
  input logic               jump_taken,
  input logic               exe_valid,
  input logic               exe_ready,
  input logic [ENTRY_W-1:0] exe_entry,
  input logic               exe_dec_pe,
  input logic [LEN_W-1:0]   exe_len,
  input logic               exe_sel_only,
  input logic               shutdown
);
  AST_TRAP_REAL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    exe_valid && exe_entry == EP_TRAP |-> !exe_dec_pe); // R3

  AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    exe_valid && !exe_ready && !jump_taken |=>
      exe_valid && $stable(exe_entry) && $stable(exe_dec_pe) && $stable(exe_len)); // R6

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    jump_taken |=> !exe_valid && dec_ready); // R7

  AST_SEL_ONLY_COND: assert property (@(posedge clk) disable iff (!rst_n)
    exe_sel_only |-> exe_valid && pe && !exe_dec_pe); // R8

  AST_SHUTDOWN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shutdown) |-> $past(exe_valid && exe_ready && !exe_dec_pe && pe && !jump_taken)); // R9

  AST_SHUTDOWN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> shutdown); // R10
endmodule

bind mode_decode_queue mode_decode_queue_chk #(.LEN_W(LEN_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dec_ready    (dec_ready),
  .pe           (pe),
  .jump_taken   (jump_taken),
  .exe_valid    (exe_valid),
  .exe_ready    (exe_ready),
  .exe_entry    (exe_entry),
  .exe_dec_pe   (exe_dec_pe),
  .exe_len      (exe_len),
  .exe_sel_only (exe_sel_only),
  .shutdown     (shutdown)
);

// File: tb/mode_decode_queue_bench.sv
module mode_decode_queue_bench;
  localparam int CLK_PERIOD = 10;
  localparam int QDEPTH     = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dec_valid = 1'b0, pe = 1'b0, pe_wr = 1'b0, jump_taken = 1'b0, exe_ready = 1'b0;
  logic [7:0] dec_opcode = '0;
  logic [3:0] dec_len = '0;
  logic       dec_ready, exe_valid, exe_dec_pe, exe_sel_only, shutdown;
  logic [6:0] exe_entry;
  logic [3:0] exe_len;

  always #(CLK_PERIOD/2) clk = ~clk;

  mode_decode_queue u_mode_decode_queue (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_ready(dec_ready),
    .dec_opcode(dec_opcode), .dec_len(dec_len), .pe(pe), .pe_wr(pe_wr),
    .jump_taken(jump_taken), .exe_valid(exe_valid), .exe_ready(exe_ready),
    .exe_entry(exe_entry), .exe_dec_pe(exe_dec_pe), .exe_len(exe_len),
    .exe_sel_only(exe_sel_only), .shutdown(shutdown)
  );

  typedef struct { int ep; bit dpe; int len; } item_t;
  item_t m_q[$];
  int    m_cnt;
  bit    m_sd, m_jprev;
  int    n_chk, n_fail;

  function automatic int ref_ep(input int op, input bit p);
    if (op < 64)             return op;          // R1
    if (op == 64)            return p ? 65 : 64; // R2
    if (op == 65)            return p ? 67 : 66; // R2
    if (op == 66 || op == 67) return p ? op + 2 : 70; // R3
    return 71;                                   // R4
  endfunction

  function automatic string ep_tag(input int ep);
    if (ep < 64) return "R1";
    if (ep < 68) return "R2";
    if (ep < 71) return "R3";
    return "R4";
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    bit ev = (m_q.size() != 0);
    chk(dec_ready == (m_q.size() < QDEPTH), "R6", "dec_ready", dec_ready, m_q.size() < QDEPTH);
    chk(exe_valid == ev, m_jprev ? "R7" : "R6", "exe_valid", exe_valid, ev);
    if (ev) begin
      chk(int'(exe_entry) == m_q[0].ep, ep_tag(m_q[0].ep), "exe_entry", exe_entry, m_q[0].ep);
      chk(exe_dec_pe == m_q[0].dpe, "R5", "exe_dec_pe", exe_dec_pe, m_q[0].dpe);
      chk(int'(exe_len) == m_q[0].len, "R5", "exe_len", exe_len, m_q[0].len);
    end
    chk(exe_sel_only == (ev && m_q[0].ep == 64 && pe), "R8", "exe_sel_only", exe_sel_only,
        ev && m_q[0].ep == 64 && pe);
    chk(shutdown == m_sd, "R9", "shutdown", shutdown, m_sd);
  endtask

  task automatic advance_model();
    bit push = dec_valid && (m_q.size() < QDEPTH);
    bit pop  = exe_ready && (m_q.size() != 0);
    bit stale = pop && !m_q[0].dpe && pe;
    item_t it;
    if (jump_taken || pe_wr) m_cnt = 0;
    else if (stale) begin
      if (m_cnt < 3) m_cnt++;
      if (m_cnt == 3) m_sd = 1'b1;
    end
    if (jump_taken) m_q.delete();
    else begin
      if (pop) void'(m_q.pop_front());
      if (push) begin
        it.ep = ref_ep(int'(dec_opcode), pe); it.dpe = pe; it.len = int'(dec_len);
        m_q.push_back(it);
      end
    end
    m_jprev = jump_taken;
  endtask

  task automatic step(input bit dv, input int op, input int ln, input bit er,
                      input bit p, input bit pw, input bit jm);
    @(negedge clk);
    dec_valid = dv; dec_opcode = 8'(op); dec_len = 4'(ln); exe_ready = er;
    pe = p; pe_wr = pw; jump_taken = jm;
    #1;
    compare();
    advance_model();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; dec_valid = 0; exe_ready = 0; pe = 0; pe_wr = 0; jump_taken = 0;
    m_q.delete(); m_cnt = 0; m_sd = 0; m_jprev = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(dec_ready == 1'b1, "R10", "reset dec_ready", dec_ready, 1);
    chk(exe_valid == 1'b0, "R10", "reset exe_valid", exe_valid, 0);
    chk(shutdown == 1'b0, "R10", "reset shutdown", shutdown, 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0;
    do_reset();
    // Fill the queue in real mode with all mode-sensitive classes (R2, R3, R6).
    step(1, 8'h40, 2, 0, 0, 0, 0);
    step(1, 8'h05, 1, 0, 0, 0, 0);
    step(1, 8'h42, 3, 0, 0, 0, 0);
    step(1, 8'h41, 1, 0, 0, 0, 0);
    step(1, 8'hC7, 5, 0, 0, 0, 0);   // refused: queue full (R6)
    // Set PE without a flush, then drain: stale path kept (R5), selector only (R8).
    step(0, 0, 0, 0, 1, 1, 0);
    step(0, 0, 0, 1, 1, 0, 0);
    step(0, 0, 0, 1, 1, 0, 0);
    step(0, 0, 0, 1, 1, 0, 0);       // third stale execution -> shutdown (R9)
    step(1, 8'h42, 2, 1, 1, 0, 0);   // protected decode of 0x42 (R3)
    step(1, 8'h41, 1, 0, 1, 0, 0);
    step(1, 8'hFF, 4, 0, 1, 0, 0);   // invalid (R4)
    step(1, 8'h40, 1, 1, 1, 0, 1);   // flush with push and pop (R7)
    step(0, 0, 0, 0, 0, 1, 0);       // shutdown held (R10)
    // Stale count cleared by a coincident pe_wr (R9).
    do_reset();
    for (int i = 0; i < 4; i++) step(1, 8'h40 + i, 1, 0, 0, 0, 0);
    step(0, 0, 0, 1, 1, 1, 0);
    step(0, 0, 0, 1, 1, 0, 0);
    step(0, 0, 0, 1, 1, 0, 0);
    step(0, 0, 0, 1, 1, 1, 0);
    step(0, 0, 0, 0, 1, 0, 0);
    // Random phase with frequent flushes and PE writes.
    for (int r = 0; r < 4; r++) begin
      bit p = 0;
      do_reset();
      for (int i = 0; i < 2500; i++) begin
        bit pw = ($urandom_range(0, 7) == 0);
        int sel = $urandom_range(0, 3);
        int op = (sel == 0) ? $urandom_range(0, 63) :
                 (sel == 3) ? $urandom_range(68, 255) : $urandom_range(64, 67);
        if (pw) p = $urandom_range(0, 1);
        step($urandom_range(0, 3) != 0, op, $urandom_range(1, 15),
             $urandom_range(0, 2) == 0, p, pw, $urandom_range(0, 11) == 0);
      end
    end
    step(0, 0, 0, 0, 0, 0, 0);
    finish_run();
  end
endmodule